// File: doc/BRIEF.md
# Timer Channel Capture/Compare Status and Control

This block is one channel of a general-purpose timer. It sits on a simple CPU register bus and holds one 8-bit status and control register. The channel runs in one of two modes. In input capture mode it watches a pin, passes it through a two-flop synchronizer, and on a selected edge latches the timer count into a capture register. In output compare mode it watches for the free-running count to become equal to a 16-bit compare value. Either kind of event sets an event flag. The flag ANDed with an interrupt enable drives a maskable interrupt request.

Software clears the flag with a two-step handshake. It first reads the register while the flag is 1, which arms a clear. It then writes 0 to the flag bit. If a new event arrives between the read and the write, the clear is cancelled, so an event is never lost. The timer counter, the compare value register, prescaling and the pulse-width features tied to the overflow-toggle and max-duty bits live outside this block. This block only stores those two bits and reads them back.

Register layout, from bit 7 down to bit 0: event flag, interrupt enable, mode B, mode A, edge select [1:0] (bits 3:2), overflow toggle, max duty. A mode A value of 0 selects input capture and a value of 1 selects output compare.

Top module: `timer_chan_ctrl`

## Requirements
- R1: After reset, rdata_o reads 8'h00, irq_o is 0 and cap_o is 0.
- R2: In capture mode (bit 4 = 0), edge select bits [3:2] choose the active pin edge: 00 none, 01 rising, 10 falling, 11 both. A pin transition first sampled at clock edge k makes the flag read 1 after edge k+2.
- R3: cap_o loads the cnt_i value present at the clock edge where a capture event sets the flag.
- R4: In compare mode (bit 4 = 1), the flag is set at the clock edge where cnt_i first equals cmp_i. Equality that persists on later cycles does not set the flag again.
- R5: A selected read while the flag is 1, followed by a selected write with wdata_i[7] = 0, clears the flag.
- R6: A write of 0 to bit 7 without a prior arming read leaves the flag unchanged. A read that sees the flag as 0 does not arm a clear.
- R7: An event between the arming read and the clearing write cancels the clear, and the flag stays 1.
- R8: When an event and a clearing write occur in the same cycle, the flag stays 1.
- R9: Writing 1 to bit 7 does not change the flag, and it disarms a pending clear.
- R10: irq_o equals flag AND interrupt enable (bit 6).
- R11: Bits 6..0 read back as last written. On an odd channel (ODD_CHAN=1), bit 5 reads 0 and ignores writes.
- R12: Bus strobes with sel_i low change nothing and do not arm a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register contents |
| cnt_i | input | CNT_W | Free-running timer count |
| cmp_i | input | CNT_W | Compare value |
| pin_i | input | 1 | Asynchronous channel pin |
| cap_o | output | CNT_W | Captured count |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the races between an event and the clearing handshake. One is an event arriving after the arming read but before the write. The other is an event landing in the very cycle of the clearing write. The bench reaches the first by toggling the pin between a read and a write while both-edge capture is selected, and then waiting out the synchronizer. It reaches the second in compare mode by changing cnt_i into equality on the same clock as the write strobe. A behavioural reference model is compared against the outputs on every cycle throughout.

// File: rtl/tchan_pkg.sv
package tchan_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = 7;

    typedef struct packed {
        logic       ie;
        logic       ms_b;
        logic       ms_a;
        logic [1:0] els;
        logic       tov;
        logic       maxd;
    } tchan_ctrl_t;
endpackage

// File: rtl/tchan_edge.sv
module tchan_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       hit_o
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[TOP-1:0], pin_i};
        st_d.last = st_q.sync[TOP];
        rise      = st_q.sync[TOP] & ~st_q.last;
        fall      = ~st_q.sync[TOP] & st_q.last;
        hit_o     = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tchan_match.sv
module tchan_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hit_o
);
    logic eq_d, eq_q;

    always_comb begin
        eq_d  = (cnt_i == cmp_i);
        hit_o = eq_d & ~eq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_d;
    end
endmodule

// File: rtl/tchan_flag.sv
module tchan_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o,
    output logic arm_o
);
    typedef struct packed {
        logic flag;
        logic arm;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event always wins over a clear in the same cycle
        if (evt_i)
            st_d.flag = 1'b1;
        else if (wr_i && !wbit_i && st_q.arm)
            st_d.flag = 1'b0;
        // arming: every write consumes it, an event cancels it,
        // a read arms only if it saw the flag set
        if (wr_i)
            st_d.arm = 1'b0;
        else if (evt_i)
            st_d.arm = 1'b0;
        else if (rd_i)
            st_d.arm = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign arm_o  = st_q.arm;
endmodule

// File: rtl/timer_chan_ctrl.sv
module timer_chan_ctrl
    import tchan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit ODD_CHAN    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             pin_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             irq_o
);
    typedef struct packed {
        tchan_ctrl_t      ctrl;
        logic [CNT_W-1:0] cap;
    } top_st_t;

    top_st_t st_d, st_q;

    logic bus_wr, bus_rd;
    logic edge_hit, match_hit;
    logic cap_evt, cmp_evt, evt;
    logic flag, arm;
    logic ms_b_next;

    assign bus_wr = sel_i & wr_i;
    assign bus_rd = sel_i & rd_i & ~wr_i;

    tchan_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .edge_sel_i (st_q.ctrl.els),
        .hit_o      (edge_hit)
    );

    tchan_match #(.CNT_W(CNT_W)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (cnt_i),
        .cmp_i (cmp_i),
        .hit_o (match_hit)
    );

    assign cap_evt = ~st_q.ctrl.ms_a & edge_hit;
    assign cmp_evt = st_q.ctrl.ms_a & match_hit;
    assign evt     = cap_evt | cmp_evt;

    tchan_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .rd_i   (bus_rd),
        .wr_i   (bus_wr),
        .wbit_i (wdata_i[FLAG_BIT]),
        .flag_o (flag),
        .arm_o  (arm)
    );

    generate
        if (ODD_CHAN) begin : g_msb_rsvd
            assign ms_b_next = 1'b0;
        end else begin : g_msb_rw
            assign ms_b_next = bus_wr ? wdata_i[5] : st_q.ctrl.ms_b;
        end
    endgenerate

    always_comb begin
        st_d           = st_q;
        st_d.ctrl.ms_b = ms_b_next;
        if (bus_wr) begin
            st_d.ctrl.ie   = wdata_i[6];
            st_d.ctrl.ms_a = wdata_i[4];
            st_d.ctrl.els  = wdata_i[3:2];
            st_d.ctrl.tov  = wdata_i[1];
            st_d.ctrl.maxd = wdata_i[0];
        end
        if (cap_evt)
            st_d.cap = cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = {flag, st_q.ctrl};
    assign cap_o   = st_q.cap;
    assign irq_o   = flag & st_q.ctrl.ie;
endmodule

// File: rtl/tchan_chk.sv
module tchan_chk #(
    parameter int CNT_W    = 16,
    parameter bit ODD_CHAN = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_i,
    input logic             wr_i,
    input logic [7:0]       wdata_i,
    input logic [7:0]       rdata_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] cap_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic             evt,
    input logic             cap_evt,
    input logic             arm
);
    a_r9_set_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && wdata_i[7] && rdata_o[7]) |=> rdata_o[7]);

    a_r6_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && !arm && rdata_o[7]) |=> rdata_o[7]);

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> rdata_o[7]);

    a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_o == $past(cnt_i)));

    a_r5_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_o[7]) |-> $past(evt));

    a_r10_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rdata_o[6] && rdata_o[7]));

    a_r11_odd_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ODD_CHAN |-> !rdata_o[5]);
endmodule

bind timer_chan_ctrl tchan_chk #(.CNT_W(CNT_W), .ODD_CHAN(ODD_CHAN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .cap_o   (cap_o),
    .cnt_i   (cnt_i),
    .evt     (evt),
    .cap_evt (cap_evt),
    .arm     (arm)
);

// File: tb/sim_timer_chan_ctrl.sv
module sim_timer_chan_ctrl;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          sel0 = 1'b0, sel1 = 1'b0, rd = 1'b0, wr = 1'b0, pin = 1'b0;
    logic [7:0]    wd = 8'h00;
    logic [CW-1:0] cnt = '0, cmp = '0;
    logic [7:0]    rd0, rd1;
    logic [CW-1:0] cap0, cap1;
    logic          irq0, irq1;

    timer_chan_ctrl #(.CNT_W(CW), .ODD_CHAN(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel0), .rd_i(rd), .wr_i(wr),
        .wdata_i(wd), .rdata_o(rd0), .cnt_i(cnt), .cmp_i(cmp),
        .pin_i(pin), .cap_o(cap0), .irq_o(irq0));

    timer_chan_ctrl #(.CNT_W(CW), .ODD_CHAN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel1), .rd_i(rd), .wr_i(wr),
        .wdata_i(wd), .rdata_o(rd1), .cnt_i(cnt), .cmp_i(cmp),
        .pin_i(pin), .cap_o(cap1), .irq_o(irq1));

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // behavioural reference for u0
    logic          m_flag, m_arm, m_ie, m_msb, m_msa, m_tov, m_max;
    logic [1:0]    m_els;
    logic [CW-1:0] m_cap;
    logic [2:0]    m_pin_hist;
    logic          m_eq_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_flag, m_arm, m_ie, m_msb, m_msa, m_tov, m_max} = '0;
            m_els = 2'b00; m_cap = '0; m_pin_hist = 3'b000; m_eq_prev = 1'b0;
        end else begin
            bit rise, fall, ev, wrs, rds, eq, capev;
            rise  = m_pin_hist[1] && !m_pin_hist[2];
            fall  = !m_pin_hist[1] && m_pin_hist[2];
            eq    = (cnt == cmp);
            capev = !m_msa && ((m_els[0] && rise) || (m_els[1] && fall));
            ev    = capev || (m_msa && eq && !m_eq_prev);
            wrs   = sel0 && wr;
            rds   = sel0 && rd && !wr;
            if (capev) m_cap = cnt;
            if (wrs) begin
                if (!wd[7] && m_arm && !ev) m_flag = 1'b0;
                m_arm = 1'b0;
                {m_ie, m_msb, m_msa, m_els, m_tov, m_max} = wd[6:0];
            end else if (rds && !ev) begin
                m_arm = m_flag;
            end
            if (ev) begin m_flag = 1'b1; m_arm = 1'b0; end
            m_pin_hist = {m_pin_hist[1:0], pin};
            m_eq_prev  = eq;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd0[7] == m_flag, "R5 model flag", rd0[7], m_flag);
            chk(rd0[6:0] == {m_ie, m_msb, m_msa, m_els, m_tov, m_max}, "R11 model ctrl",
                rd0[6:0], {m_ie, m_msb, m_msa, m_els, m_tov, m_max});
            chk(irq0 == (m_flag & m_ie), "R10 model irq", irq0, m_flag & m_ie);
            chk(cap0 == m_cap, "R3 model capture", cap0, m_cap);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] d);
        @(negedge clk); sel0 = 1'b1; wr = 1'b1; wd = d;
        @(negedge clk); sel0 = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(output logic [7:0] v);
        @(negedge clk); sel0 = 1'b1; rd = 1'b1; v = rd0;
        @(negedge clk); sel0 = 1'b0; rd = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        tick(3);
        chk(rd0 == 8'h00 && irq0 == 1'b0 && cap0 == '0, "R1 reset", {rd0, irq0}, 9'h0);
        rst_n = 1'b1;
        tick(2);
        chk(rd0 == 8'h00, "R1 after release", rd0, 8'h00);

        // rising capture, ie=1
        bus_wr(8'h44);
        chk(rd0 == 8'h44, "R11 readback", rd0, 8'h44);
        cnt = 16'h1234;
        @(negedge clk); pin = 1'b1;
        tick(2);
        chk(rd0[7] == 1'b0, "R2 sync latency", rd0[7], 1'b0);
        tick(1);
        chk(rd0[7] == 1'b1, "R2 rising capture", rd0[7], 1'b1);
        chk(cap0 == 16'h1234, "R3 captured count", cap0, 16'h1234);
        chk(irq0 == 1'b1, "R10 irq asserted", irq0, 1'b1);

        // clear, then falling edge must be ignored in rising-only mode
        bus_rd(v);
        chk(v[7] == 1'b1, "R5 arming read sees flag", v[7], 1'b1);
        bus_wr(8'h44);
        chk(rd0[7] == 1'b0, "R5 clear", rd0[7], 1'b0);
        @(negedge clk); pin = 1'b0;
        tick(4);
        chk(rd0[7] == 1'b0, "R2 falling ignored", rd0[7], 1'b0);

        // both edges
        bus_wr(8'h4C);
        cnt = 16'h0ABC;
        @(negedge clk); pin = 1'b1;
        tick(3);
        chk(rd0[7] == 1'b1 && cap0 == 16'h0ABC, "R2 both-edge capture", cap0, 16'h0ABC);

        // write 0 without arming
        bus_wr(8'h4C);
        chk(rd0[7] == 1'b1, "R6 unarmed write", rd0[7], 1'b1);
        // write 1 disarms
        bus_rd(v);
        bus_wr(8'hCC);
        chk(rd0 == 8'hCC, "R9 write one keeps flag", rd0, 8'hCC);
        bus_wr(8'h4C);
        chk(rd0[7] == 1'b1, "R9 disarmed", rd0[7], 1'b1);

        // event between read and write
        bus_rd(v);
        cnt = 16'h0BBB;
        @(negedge clk); pin = 1'b0;
        tick(4);
        bus_wr(8'h4C);
        chk(rd0[7] == 1'b1, "R7 clear cancelled", rd0[7], 1'b1);
        chk(cap0 == 16'h0BBB, "R3 recapture", cap0, 16'h0BBB);
        bus_rd(v);
        bus_wr(8'h4C);
        chk(rd0[7] == 1'b0, "R5 clear after race", rd0[7], 1'b0);

        // compare mode
        cmp = 16'h0010;
        cnt = 16'h000C;
        bus_wr(8'h50);
        repeat (4) begin
            @(negedge clk);
            chk(rd0[7] == 1'b0, "R4 before match", rd0[7], 1'b0);
            cnt = cnt + 16'd1;
        end
        tick(1);
        chk(rd0[7] == 1'b1, "R4 match sets flag", rd0[7], 1'b1);
        bus_rd(v);
        bus_wr(8'h50);
        tick(5);
        chk(rd0[7] == 1'b0, "R4 held equality no repeat", rd0[7], 1'b0);

        // event in the same cycle as the clearing write
        @(negedge clk); cnt = 16'h000F;
        @(negedge clk); cnt = 16'h0010;
        @(negedge clk); cnt = 16'h000F;
        chk(rd0[7] == 1'b1, "R4 second match", rd0[7], 1'b1);
        bus_rd(v);
        @(negedge clk); sel0 = 1'b1; wr = 1'b1; wd = 8'h50; cnt = 16'h0010;
        @(negedge clk); sel0 = 1'b0; wr = 1'b0;
        chk(rd0[7] == 1'b1, "R8 set beats clear", rd0[7], 1'b1);
        bus_wr(8'h50);
        chk(rd0[7] == 1'b1, "R6 event disarmed", rd0[7], 1'b1);

        // interrupt mask
        bus_wr(8'h10);
        chk(irq0 == 1'b0 && rd0 == 8'h90, "R10 masked", {rd0, irq0}, {8'h90, 1'b0});
        bus_wr(8'h50);
        chk(irq0 == 1'b1, "R10 unmasked", irq0, 1'b1);

        // strobes without select
        @(negedge clk); wr = 1'b1; wd = 8'h00;
        @(negedge clk); wr = 1'b0;
        chk(rd0 == 8'hD0, "R12 unselected write", rd0, 8'hD0);
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        bus_wr(8'h50);
        chk(rd0[7] == 1'b1, "R12 unselected read no arm", rd0[7], 1'b1);

        // read of flag 0 does not arm
        bus_rd(v); bus_wr(8'h50);
        chk(rd0[7] == 1'b0, "R5 clear", rd0[7], 1'b0);
        bus_rd(v);
        @(negedge clk); cnt = 16'h000F;
        @(negedge clk); cnt = 16'h0010;
        bus_wr(8'h50);
        chk(rd0[7] == 1'b1, "R6 zero read no arm", rd0[7], 1'b1);

        // odd channel reserved bit
        @(negedge clk); sel1 = 1'b1; wr = 1'b1; wd = 8'h3F;
        @(negedge clk); sel1 = 1'b0; wr = 1'b0;
        chk(rd1 == 8'h1F, "R11 odd reserved bit", rd1, 8'h1F);

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule